// File: doc/BRIEF.md
# Single-Channel Peripheral/Memory Transfer Engine

The block is one channel of a transfer engine. It moves data items between a peripheral location and memory, one item for each hardware request, with no processor involvement. Software sets up the channel through a small register interface: two base addresses, an item count, a size for each side, an increment enable for each side, a direction, circular operation, a secure attribute and an enable. For every request that is served, the channel reads one item from the source side on a simple bus master port and writes it to the destination side. It then acknowledges the request for one cycle.

The channel steps through addresses in hidden working registers. The programmed base registers never change during a transfer. A down-counter tracks the remaining items. When the counter reaches zero, the channel either stops or, in circular mode, reloads the count and both working addresses and carries on. A per-channel secure bit decides which software world may see and program the channel. Every bus transfer carries that attribute.

Register select codes: 0 = control, 1 = peripheral base, 2 = memory base, 3 = item count, 4 = status.

Control word bits:

| Bits | Field |
|---|---|
| [0] | enable |
| [1] | circular |
| [2] | direction (0 = peripheral to memory, 1 = memory to peripheral) |
| [3] | peripheral increment |
| [4] | memory increment |
| [6:5] | peripheral size |
| [8:7] | memory size |
| [9] | secure |

Status bit [0] is the completion flag. Unused select codes read as zero.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, every register reads zero, and busReq and dmaAck are low.
- R2: A served request produces one read, using the source side's address and size, followed by one write to the destination side. The write carries the data that was read. Direction 0 reads the peripheral side and writes the memory side; direction 1 does the reverse. dmaAck is high for exactly one cycle, in the cycle after the write's busAck.
- R3: The count register decreases by one after each item and reads back the remaining count.
- R4: The size fields use the encoding 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 = 4 bytes (reserved). A side with its increment enable set moves its address by its own size after each item. A side with its increment enable clear keeps its address fixed.
- R5: The base registers keep their programmed values while transfers run. Each write that sets the enable bit from 0 to 1 restarts the working addresses at the bases.
- R6: With circular clear, no request is served while the count is zero. The completion flag (status bit 0) sets when the count reaches zero, and any allowed write to the status register clears it.
- R7: With circular set, the item that brings the count to zero reloads the count with its last written value and both working addresses with the bases. Service then continues, and the completion flag still sets.
- R8: While the channel is enabled, writes to the count, base address, size, increment, direction, circular and secure fields are ignored. The enable bit stays writable.
- R9: Clearing the enable bit leaves the control fields, the base addresses and the remaining count unchanged.
- R10: A non-secure access (cfgSecure = 0) to a channel whose secure bit is set reads zero and writes nothing. The secure bit can be changed only by a secure access.
- R11: busSecure equals the channel's secure bit on every bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSel | input | 3 | Register select |
| cfgWr | input | 1 | Register write strobe |
| cfgSecure | input | 1 | Access comes from the secure world |
| cfgWdata | input | REG_W | Register write data |
| cfgRdata | output | REG_W | Register read data (combinational) |
| dmaReq | input | 1 | Hardware request, held until acknowledged |
| dmaAck | output | 1 | One-cycle request acknowledge |
| busReq | output | 1 | Bus transfer pending |
| busWr | output | 1 | Bus transfer is a write |
| busSecure | output | 1 | Security attribute of the transfer |
| busSize | output | 2 | Item size code of the transfer |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data |
| busAck | input | 1 | Bus completes the current transfer |

## Verification
The bench uses the default widths: 32-bit addresses, data and registers, and a 16-bit counter. These widths let the stimulus place peripheral and memory windows at distinct high addresses. They also make the counter wide enough that a wrapped decrement could never be mistaken for a reload. Small counts of 1 to 3 items are enough to reach the zero boundary, the circular wrap (which happens twice in one run), and the restart of the working addresses after the channel is enabled again.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } chanState_e;

  typedef struct packed {
    logic rdPhase;
    logic wrPhase;
    logic latchData;
    logic finishItem;
  } ctrlStrobe_t;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_PBASE = 3'd1;
  localparam logic [2:0] SEL_MBASE = 3'd2;
  localparam logic [2:0] SEL_COUNT = 3'd3;
  localparam logic [2:0] SEL_STAT  = 3'd4;

  localparam int CTRL_BITS = 10;

  // byte step for a size code; reserved code 11 behaves as a word
  function automatic logic [2:0] stepOf(input logic [1:0] sz);
    case (sz)
      2'b00:   stepOf = 3'd1;
      2'b01:   stepOf = 3'd2;
      default: stepOf = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        cntZero,
  input  logic        dmaReq,
  input  logic        busAck,
  output ctrlStrobe_t stb,
  output logic        busReq,
  output logic        busWr,
  output logic        dmaAck
);

  chanState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (chanEn && dmaReq && !cntZero) stateD = ST_RD;
      ST_RD:   if (busAck) stateD = ST_WR;
      ST_WR:   if (busAck) stateD = ST_FIN;
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.rdPhase    = (stateQ == ST_RD);
    stb.wrPhase    = (stateQ == ST_WR);
    stb.latchData  = (stateQ == ST_RD) && busAck;
    stb.finishItem = (stateQ == ST_FIN);
  end

  assign busReq = (stateQ == ST_RD) || (stateQ == ST_WR);
  assign busWr  = (stateQ == ST_WR);
  assign dmaAck = (stateQ == ST_FIN);

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgSel,
  input  logic              cfgWr,
  input  logic              cfgSecure,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  ctrlStrobe_t       stb,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busSecure,
  output logic              chanEn,
  output logic              cntZero
);

  logic              enQ, circQ, dirQ, pIncQ, mIncQ, secQ, doneQ;
  logic [1:0]        pSizeQ, mSizeQ;
  logic [ADDR_W-1:0] pBaseQ, mBaseQ, pWorkQ, mWorkQ;
  logic [CNT_W-1:0]  cntQ, reloadQ;
  logic [DATA_W-1:0] dataQ;

  logic accessOk, wrOk, ctrlWr, enRise, lastItem, cfgLock;

  assign accessOk = cfgSecure || !secQ;
  assign wrOk     = cfgWr && accessOk;
  assign ctrlWr   = wrOk && (cfgSel == SEL_CTRL);
  assign enRise   = ctrlWr && cfgWdata[0] && !enQ;
  assign cfgLock  = enQ;
  assign lastItem = stb.finishItem && (cntQ == CNT_W'(1));

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {enQ, circQ, dirQ, pIncQ, mIncQ, secQ} <= '0;
      pSizeQ <= '0;
      mSizeQ <= '0;
    end else if (ctrlWr) begin
      enQ <= cfgWdata[0];
      if (!cfgLock) begin
        circQ  <= cfgWdata[1];
        dirQ   <= cfgWdata[2];
        pIncQ  <= cfgWdata[3];
        mIncQ  <= cfgWdata[4];
        pSizeQ <= cfgWdata[6:5];
        mSizeQ <= cfgWdata[8:7];
        if (cfgSecure) secQ <= cfgWdata[9];
      end
    end
  end

  // base addresses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pBaseQ <= '0;
      mBaseQ <= '0;
    end else if (wrOk && !cfgLock) begin
      if (cfgSel == SEL_PBASE) pBaseQ <= cfgWdata[ADDR_W-1:0];
      if (cfgSel == SEL_MBASE) mBaseQ <= cfgWdata[ADDR_W-1:0];
    end
  end

  // item counter, its reload value and the completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      reloadQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      if (stb.finishItem) begin
        cntQ <= (lastItem && circQ) ? reloadQ : cntQ - CNT_W'(1);
      end else if (wrOk && !cfgLock && cfgSel == SEL_COUNT) begin
        cntQ    <= cfgWdata[CNT_W-1:0];
        reloadQ <= cfgWdata[CNT_W-1:0];
      end
      if (lastItem) doneQ <= 1'b1;
      else if (wrOk && cfgSel == SEL_STAT) doneQ <= 1'b0;
    end
  end

  // hidden working addresses and data holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pWorkQ <= '0;
      mWorkQ <= '0;
      dataQ  <= '0;
    end else begin
      if (enRise || (lastItem && circQ)) begin
        pWorkQ <= pBaseQ;
        mWorkQ <= mBaseQ;
      end else if (stb.finishItem) begin
        if (pIncQ) pWorkQ <= pWorkQ + ADDR_W'(stepOf(pSizeQ));
        if (mIncQ) mWorkQ <= mWorkQ + ADDR_W'(stepOf(mSizeQ));
      end
      if (stb.latchData) dataQ <= busRdata;
    end
  end

  // source side is memory when dirQ is set, destination the other side
  logic useMem;
  assign useMem    = stb.rdPhase ? dirQ : !dirQ;
  assign busAddr   = useMem ? mWorkQ : pWorkQ;
  assign busSize   = useMem ? mSizeQ : pSizeQ;
  assign busWdata  = dataQ;
  assign busSecure = secQ;
  assign chanEn    = enQ;
  assign cntZero   = (cntQ == '0);

  always_comb begin
    cfgRdata = '0;
    if (accessOk) begin
      case (cfgSel)
        SEL_CTRL:  cfgRdata = REG_W'({secQ, mSizeQ, pSizeQ, mIncQ, pIncQ, dirQ, circQ, enQ});
        SEL_PBASE: cfgRdata = REG_W'(pBaseQ);
        SEL_MBASE: cfgRdata = REG_W'(mBaseQ);
        SEL_COUNT: cfgRdata = REG_W'(cntQ);
        SEL_STAT:  cfgRdata = REG_W'(doneQ);
        default:   cfgRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgSel,
  input  logic              cfgWr,
  input  logic              cfgSecure,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              dmaReq,
  output logic              dmaAck,
  output logic              busReq,
  output logic              busWr,
  output logic              busSecure,
  output logic [1:0]        busSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck
);

  ctrlStrobe_t stb;
  logic chanEn, cntZero;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .cntZero(cntZero),
    .dmaReq(dmaReq), .busAck(busAck), .stb(stb),
    .busReq(busReq), .busWr(busWr), .dmaAck(dmaAck)
  );

  dma_chan_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWr(cfgWr),
    .cfgSecure(cfgSecure), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .stb(stb), .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busSecure(busSecure), .chanEn(chanEn),
    .cntZero(cntZero)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaAck,
  input logic              busReq,
  input logic              busWr,
  input logic              busAck,
  input logic              enQ,
  input logic              circQ,
  input logic [CNT_W-1:0]  cntQ,
  input logic [CNT_W-1:0]  reloadQ,
  input logic [ADDR_W-1:0] pBaseQ,
  input logic [ADDR_W-1:0] mBaseQ
);

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |=> !dmaAck);

  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWr) |-> $past(busReq && !busWr && busAck));

  a_r6_no_start_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> (cntQ != '0));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && cntQ != CNT_W'(1)) |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  a_r7_circ_reload: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && circQ && cntQ == CNT_W'(1)) |=> (cntQ == $past(reloadQ)));

  a_r5_base_hold: assert property (@(posedge clk) disable iff (!rstN)
    enQ |=> ($stable(pBaseQ) && $stable(mBaseQ)));

endmodule

bind dma_chan_top dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .dmaAck(dmaAck), .busReq(busReq), .busWr(busWr),
  .busAck(busAck), .enQ(u_dp.enQ), .circQ(u_dp.circQ), .cntQ(u_dp.cntQ),
  .reloadQ(u_dp.reloadQ), .pBaseQ(u_dp.pBaseQ), .mBaseQ(u_dp.mBaseQ)
);

// File: tb/dma_chan_top_tb.sv
module dma_chan_top_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int REG_W  = 32;
  localparam logic [31:0] RD_KEY = 32'h5A5A_00C3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        cfgSel = '0;
  logic              cfgWr = 1'b0;
  logic              cfgSecure = 1'b0;
  logic [REG_W-1:0]  cfgWdata = '0;
  logic [REG_W-1:0]  cfgRdata;
  logic              dmaReq = 1'b0;
  logic              dmaAck;
  logic              busReq, busWr, busSecure;
  logic [1:0]        busSize;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata;
  logic              busAck = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWr(cfgWr), .cfgSecure(cfgSecure),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .dmaReq(dmaReq), .dmaAck(dmaAck),
    .busReq(busReq), .busWr(busWr), .busSecure(busSecure), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  // bus responder: one wait cycle, then a single-cycle completion
  assign busRdata = busAddr ^ RD_KEY;
  always @(posedge clk) busAck <= busReq && !busAck;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] rdA;
    logic [31:0] wrA;
    logic [1:0]  rdS;
    logic [1:0]  wrS;
    logic        sec;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] seenRdA;
  logic [1:0]  seenRdS;

  // monitor: compares every completed read/write pair with the scoreboard
  always @(negedge clk) begin
    if (rstN && busReq && busAck) begin
      if (!busWr) begin
        seenRdA = busAddr;
        seenRdS = busSize;
        chk("R11 read secure attr", {31'd0, busSecure},
            expQ.size() > 0 ? {31'd0, expQ[0].sec} : 32'd0);
      end else if (expQ.size() == 0) begin
        chk("R2 unexpected write", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk("R2/R4 read addr", seenRdA, e.rdA);
        chk("R2/R4 write addr", busAddr, e.wrA);
        chk("R2 write data", busWdata, e.rdA ^ RD_KEY);
        chk("R2/R4 sizes", {28'd0, seenRdS, busSize}, {28'd0, e.rdS, e.wrS});
        chk("R11 write secure attr", {31'd0, busSecure}, {31'd0, e.sec});
      end
    end
  end

  task automatic regWr(input logic [2:0] sel, input logic [31:0] d, input logic sec);
    @(negedge clk);
    cfgSel = sel; cfgWdata = d; cfgSecure = sec; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] sel, input logic sec, output logic [31:0] d);
    @(negedge clk);
    cfgSel = sel; cfgSecure = sec;
    #1 d = cfgRdata;
  endtask

  task automatic regChk(input string req, input logic [2:0] sel, input logic sec,
                        input logic [31:0] exp);
    logic [31:0] d;
    regRd(sel, sec, d);
    chk(req, d, exp);
  endtask

  // driver: push the expected pair, raise the request, wait for the ack
  task automatic doItem(input logic [31:0] pA, input logic [31:0] mA, input logic dir,
                        input logic [1:0] pS, input logic [1:0] mS, input logic sec);
    exp_t e;
    bit got = 0;
    e.rdA = dir ? mA : pA;
    e.wrA = dir ? pA : mA;
    e.rdS = dir ? mS : pS;
    e.wrS = dir ? pS : mS;
    e.sec = sec;
    expQ.push_back(e);
    @(negedge clk);
    dmaReq = 1'b1;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (dmaAck) got = 1;
    end
    dmaReq = 1'b0;
    chk("R2 request acknowledged", {31'd0, got}, 32'd1);
    @(negedge clk);
    chk("R2 ack lasts one cycle", {31'd0, dmaAck}, 32'd0);
  endtask

  task automatic noService(input string req);
    bit moved = 0;
    @(negedge clk);
    dmaReq = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busReq || dmaAck) moved = 1;
    end
    dmaReq = 1'b0;
    chk(req, {31'd0, moved}, 32'd0);
  endtask

  function automatic logic [31:0] ctrlWord(bit en, bit circ, bit dir, bit pInc, bit mInc,
                                           logic [1:0] pS, logic [1:0] mS, bit sec);
    return {22'd0, sec, mS, pS, mInc, pInc, dir, circ, en};
  endfunction

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    logic [31:0] cA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 5; s++) regChk("R1 reset register", 3'(s), 1'b1, 32'd0);
    chk("R1 reset busReq", {31'd0, busReq}, 32'd0);
    chk("R1 reset dmaAck", {31'd0, dmaAck}, 32'd0);

    // linear, peripheral -> memory, fixed peripheral (half), stepping memory (word)
    cA = ctrlWord(0, 0, 0, 0, 1, 2'b01, 2'b10, 0);
    regWr(3'd0, cA, 1'b0);
    regWr(3'd1, 32'h4000_0010, 1'b0);
    regWr(3'd2, 32'h2000_0100, 1'b0);
    regWr(3'd3, 32'd3, 1'b0);
    regWr(3'd0, cA | 32'd1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      doItem(32'h4000_0010, 32'h2000_0100 + 32'(4 * k), 0, 2'b01, 2'b10, 0);
      regChk("R3 count after item", 3'd3, 1'b0, 32'(2 - k));
      if (k == 1) regChk("R6 flag clear before zero", 3'd4, 1'b0, 32'd0);
    end
    regChk("R6 flag set at zero", 3'd4, 1'b0, 32'd1);
    noService("R6 no service at zero count");
    regChk("R5 peripheral base held", 3'd1, 1'b0, 32'h4000_0010);
    regChk("R5 memory base held", 3'd2, 1'b0, 32'h2000_0100);

    // R8 writes while enabled
    regWr(3'd3, 32'd9, 1'b0);
    regChk("R8 count write ignored", 3'd3, 1'b0, 32'd0);
    regWr(3'd1, 32'h1111_0000, 1'b0);
    regChk("R8 base write ignored", 3'd1, 1'b0, 32'h4000_0010);
    regWr(3'd0, ctrlWord(1, 1, 1, 1, 0, 2'b00, 2'b00, 0), 1'b0);
    regChk("R8 control fields locked", 3'd0, 1'b0, cA | 32'd1);

    // R9 disable keeps configuration
    regWr(3'd0, 32'd0, 1'b0);
    regChk("R9 control kept after disable", 3'd0, 1'b0, cA);
    regChk("R9 memory base kept", 3'd2, 1'b0, 32'h2000_0100);
    regWr(3'd4, 32'd0, 1'b0);
    regChk("R6 flag cleared by write", 3'd4, 1'b0, 32'd0);

    // R5 re-enable restarts at the bases
    regWr(3'd3, 32'd2, 1'b0);
    regWr(3'd0, cA | 32'd1, 1'b0);
    doItem(32'h4000_0010, 32'h2000_0100, 0, 2'b01, 2'b10, 0);
    doItem(32'h4000_0010, 32'h2000_0104, 0, 2'b01, 2'b10, 0);

    // circular, memory -> peripheral, byte peripheral, reserved-size memory
    regWr(3'd0, 32'd0, 1'b0);
    cA = ctrlWord(0, 1, 1, 1, 1, 2'b00, 2'b11, 0);
    regWr(3'd0, cA, 1'b0);
    regWr(3'd1, 32'h4000_0200, 1'b0);
    regWr(3'd2, 32'h2000_0800, 1'b0);
    regWr(3'd3, 32'd2, 1'b0);
    regWr(3'd4, 32'd0, 1'b0);
    regWr(3'd0, cA | 32'd1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      doItem(32'h4000_0200 + 32'(k % 2), 32'h2000_0800 + 32'(4 * (k % 2)),
             1, 2'b00, 2'b11, 0);
      regChk("R7 count reload", 3'd3, 1'b0, (k % 2) ? 32'd2 : 32'd1);
    end
    regChk("R7 flag set on wrap", 3'd4, 1'b0, 32'd1);

    // security
    regWr(3'd0, 32'd0, 1'b0);
    regWr(3'd0, ctrlWord(0, 0, 0, 0, 0, 2'b10, 2'b10, 1), 1'b0);
    regChk("R10 secure bit needs secure write", 3'd0, 1'b0,
           ctrlWord(0, 0, 0, 0, 0, 2'b10, 2'b10, 0));
    cA = ctrlWord(0, 0, 0, 0, 0, 2'b10, 2'b10, 1);
    regWr(3'd0, cA, 1'b1);
    regWr(3'd1, 32'h4000_0300, 1'b1);
    regWr(3'd2, 32'h2000_0900, 1'b1);
    regWr(3'd3, 32'd1, 1'b1);
    regChk("R10 non-secure control read zero", 3'd0, 1'b0, 32'd0);
    regChk("R10 non-secure base read zero", 3'd1, 1'b0, 32'd0);
    regChk("R10 non-secure count read zero", 3'd3, 1'b0, 32'd0);
    regWr(3'd1, 32'h0000_1234, 1'b0);
    regChk("R10 non-secure write ignored", 3'd1, 1'b1, 32'h4000_0300);
    regWr(3'd0, cA | 32'd1, 1'b0);
    regChk("R10 non-secure enable ignored", 3'd0, 1'b1, cA);
    regWr(3'd0, cA | 32'd1, 1'b1);
    doItem(32'h4000_0300, 32'h2000_0900, 0, 2'b10, 2'b10, 1);
    regChk("R3 secure count at zero", 3'd3, 1'b1, 32'd0);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(expQ.size()), 32'd0);
    finished = 1;
    finish();
  end

endmodule